// File: doc/BRIEF.md
# Monotonic 64-bit Event Counter

This block keeps a 64-bit count that can only move forward during normal operation. The count is held as two halves of equal width, a low half and a high half. A single write port selects one half. A mode bit sets what a write does. With the mode bit clear, a write loads the selected half with the written data. With the mode bit set, a write only asks the counter to advance by one, and the written data is thrown away. The full value is the high half placed above the low half, and a carry out of the low half moves into the high half.

When an advance wraps the high half, the block raises a sticky overflow flag. While the flag is set, the count is frozen and both halves read as zero. The flag is cleared only by a high-half write made with the mode bit clear. An advance request is refused when the overflow flag is set or when the external time-invalid input is high. A refused request produces a one-cycle pulse on the error output.

Top module: `mono_event_counter`

## Requirements
- R1: After reset, both halves read zero, the overflow flag and the error output are low, and the mode bit is clear, so the first write loads its data.
- R2: With the mode bit clear, a write loads the half chosen by `wr_sel_hi_i` (0 = low, 1 = high) with `wr_data_i`. The other half keeps its value. The new value is visible on the outputs in the cycle after the write edge.
- R3: With the mode bit set, a write with either value of `wr_sel_hi_i` adds one to the 64-bit count `{cnt_hi_o, cnt_lo_o}`, and `wr_data_i` has no effect.
- R4: An advance that takes the low half from all ones to zero also adds one to the high half.
- R5: An advance that takes the full count from all ones sets `ovf_o`. While `ovf_o` is high, both `cnt_lo_o` and `cnt_hi_o` read zero.
- R6: While `ovf_o` is high, an advance request leaves the count and the flag unchanged, and `inc_err_o` goes high for the following cycle.
- R7: While `time_invalid_i` is high, an advance request leaves the count unchanged, and `inc_err_o` goes high for the following cycle.
- R8: A high-half write with the mode bit clear clears `ovf_o`. A low-half write with the mode bit clear does not clear it.
- R9: A mode write (`mode_we_i`) takes effect from the next cycle. A data write in the same cycle as a mode write acts under the old mode.
- R10: `inc_err_o` is high only in the cycle after a refused advance request. It stays low after loads, after accepted advances and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the mode bit |
| mode_i | input | 1 | New mode bit value (1 = advance, 0 = load) |
| wr_en_i | input | 1 | Counter write strobe |
| wr_sel_hi_i | input | 1 | Half select for the write (0 = low, 1 = high) |
| wr_data_i | input | HALF_W | Write data, used only in load mode |
| time_invalid_i | input | 1 | External time-invalid condition, blocks advances |
| cnt_lo_o | output | HALF_W | Low half of the count (zero while overflowed) |
| cnt_hi_o | output | HALF_W | High half of the count (zero while overflowed) |
| ovf_o | output | 1 | Sticky overflow flag |
| inc_err_o | output | 1 | One-cycle pulse for a refused advance |

## Verification
The case that is hardest to reach from the ports is the wrap of the full count. Reaching it by advancing alone would take 2^64 writes. The stimulus therefore uses load mode to preset the high half to all ones and the low half to one below all ones. It then switches to advance mode and issues two advances, which walks the count through the final carry into the overflow state. From there it checks the refused advances, a low-half load that leaves the flag set, and a high-half load that releases the frozen state. A long random phase then mixes loads, advances, mode changes and the time-invalid input. During that phase every cycle is compared against a behavioural 64-bit model.

// File: rtl/mec_pkg.sv
package mec_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/mec_half.sv
module mec_half #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         all_ones_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (ld_i)  q <= ld_data_i;
    else if (inc_i) q <= q + W'(1);
  end

  assign q_o        = q;
  assign all_ones_o = &q;
endmodule

// File: rtl/mec_ctrl.sv
module mec_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_we_i,
  input  logic mode_i,
  input  logic wr_en_i,
  input  logic time_invalid_i,
  input  logic wrap_i,
  input  logic hi_load_i,
  output logic mode_o,
  output logic ovf_o,
  output logic err_o,
  output logic inc_go_o
);
  logic mode_q, ovf_q, err_q;
  logic inc_req;

  assign inc_req  = wr_en_i & mode_q;
  assign inc_go_o = inc_req & ~ovf_q & ~time_invalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_i;
      // a high load in load mode is the only release from overflow
      if (hi_load_i)   ovf_q <= 1'b0;
      else if (wrap_i) ovf_q <= 1'b1;
      err_q <= inc_req & (ovf_q | time_invalid_i);
    end
  end

  assign mode_o = mode_q;
  assign ovf_o  = ovf_q;
  assign err_o  = err_q;
endmodule

// File: rtl/mono_event_counter.sv
module mono_event_counter
  import mec_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              mode_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              time_invalid_i,
  output logic [HALF_W-1:0] cnt_lo_o,
  output logic [HALF_W-1:0] cnt_hi_o,
  output logic              ovf_o,
  output logic              inc_err_o
);
  logic              mode_q;
  logic              ovf_q;
  logic              inc_go;
  logic [NUM_HALVES:0] carry;
  logic [NUM_HALVES-1:0] ld;
  logic [NUM_HALVES-1:0] ones;
  logic [HALF_W-1:0] half_q [NUM_HALVES];

  assign carry[0] = inc_go;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    assign ld[g] = wr_en_i & ~mode_q & (wr_sel_hi_i == 1'(g));

    mec_half #(.W(HALF_W)) u_half (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_i       (ld[g]),
      .ld_data_i  (wr_data_i),
      .inc_i      (carry[g]),
      .q_o        (half_q[g]),
      .all_ones_o (ones[g])
    );

    assign carry[g+1] = carry[g] & ones[g];
  end

  mec_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_we_i      (mode_we_i),
    .mode_i         (mode_i),
    .wr_en_i        (wr_en_i),
    .time_invalid_i (time_invalid_i),
    .wrap_i         (carry[NUM_HALVES]),
    .hi_load_i      (ld[HALF_HI]),
    .mode_o         (mode_q),
    .ovf_o          (ovf_q),
    .err_o          (inc_err_o),
    .inc_go_o       (inc_go)
  );

  // overflowed count reads as zero
  assign cnt_lo_o = ovf_q ? '0 : half_q[HALF_LO];
  assign cnt_hi_o = ovf_q ? '0 : half_q[HALF_HI];
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/mec_checker.sv
module mec_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_q,
  input logic         wr_en_i,
  input logic         wr_sel_hi_i,
  input logic [W-1:0] wr_data_i,
  input logic         time_invalid_i,
  input logic [W-1:0] cnt_lo_o,
  input logic [W-1:0] cnt_hi_o,
  input logic         ovf_o,
  input logic         inc_err_o
);
  a_r5_ovf_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_lo_o == '0 && cnt_hi_o == '0));

  a_r3_advance_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_q && !ovf_o && !time_invalid_i) |=>
      (ovf_o || {cnt_hi_o, cnt_lo_o} == $past({cnt_hi_o, cnt_lo_o}) + 1'b1));

  a_r2_low_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_q && !wr_sel_hi_i && !ovf_o) |=>
      (cnt_lo_o == $past(wr_data_i) && cnt_hi_o == $past(cnt_hi_o)));

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(wr_en_i && !mode_q && wr_sel_hi_i)) |=> ovf_o);

  a_r6_err_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_q && ovf_o) |=> inc_err_o);

  a_r7_err_on_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_q && time_invalid_i) |=>
      (inc_err_o && $stable({cnt_hi_o, cnt_lo_o})));

  a_r8_hi_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_q && wr_sel_hi_i) |=> (!ovf_o && cnt_hi_o == $past(wr_data_i)));

  a_r10_no_spurious_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && mode_q) |=> !inc_err_o);
endmodule

bind mono_event_counter mec_checker #(.W(HALF_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_q         (mode_q),
  .wr_en_i        (wr_en_i),
  .wr_sel_hi_i    (wr_sel_hi_i),
  .wr_data_i      (wr_data_i),
  .time_invalid_i (time_invalid_i),
  .cnt_lo_o       (cnt_lo_o),
  .cnt_hi_o       (cnt_hi_o),
  .ovf_o          (ovf_o),
  .inc_err_o      (inc_err_o)
);

// File: tb/mono_event_counter_bench.sv
module mono_event_counter_bench;
  localparam int HW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_we = 1'b0, mode_v = 1'b0, wr_en = 1'b0, wr_hi = 1'b0, tinv = 1'b0;
  logic [HW-1:0] wr_data = '0;
  logic [HW-1:0] lo_o, hi_o;
  logic          ovf_o, err_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // behavioural reference state
  longint unsigned m_val = 0;
  bit m_mode = 0, m_ovf = 0, m_err = 0;

  always #5 clk = ~clk;

  mono_event_counter #(.HALF_W(HW)) u_mono_event_counter (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .mode_we_i      (mode_we),
    .mode_i         (mode_v),
    .wr_en_i        (wr_en),
    .wr_sel_hi_i    (wr_hi),
    .wr_data_i      (wr_data),
    .time_invalid_i (tinv),
    .cnt_lo_o       (lo_o),
    .cnt_hi_o       (hi_o),
    .ovf_o          (ovf_o),
    .inc_err_o      (err_o)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  task automatic compare(string tag);
    logic [HW-1:0] e_lo, e_hi;
    e_lo = m_ovf ? '0 : m_val[HW-1:0];
    e_hi = m_ovf ? '0 : m_val[2*HW-1:HW];
    checks++;
    if (lo_o !== e_lo || hi_o !== e_hi || ovf_o !== m_ovf || err_o !== m_err) begin
      failures++;
      $display("FAIL %s: actual hi=%h lo=%h ovf=%b err=%b expected hi=%h lo=%h ovf=%b err=%b",
               tag, hi_o, lo_o, ovf_o, err_o, e_hi, e_lo, m_ovf, m_err);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit mwe, bit mv, bit we, bit sel_hi, logic [HW-1:0] d, bit ti, string tag);
    mode_we = mwe; mode_v = mv; wr_en = we; wr_hi = sel_hi; wr_data = d; tinv = ti;
    @(posedge clk);
    m_err = we && m_mode && (m_ovf || ti);
    if (we && !m_mode) begin
      if (sel_hi) begin
        m_val = {d, m_val[HW-1:0]};
        m_ovf = 0;
      end else begin
        m_val = {m_val[2*HW-1:HW], d};
      end
    end else if (we && m_mode && !m_ovf && !ti) begin
      if (m_val == 64'hFFFF_FFFF_FFFF_FFFF) begin
        m_ovf = 1;
        m_val = 0;
      end else begin
        m_val = m_val + 1;
      end
    end
    if (mwe) m_mode = mv;
    @(negedge clk);
    mode_we = 0; wr_en = 0; tinv = 0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step(0, 0, 1, 0, 32'h1234_5678, 0, "R1");
    step(0, 0, 1, 1, 32'h0000_A5A5, 0, "R2");
    step(0, 0, 1, 0, 32'h0BAD_F00D, 0, "R2");
    step(1, 1, 1, 0, 32'h0000_DEAD, 0, "R9");
    step(0, 0, 1, 0, 32'hFFFF_0000, 0, "R3");
    step(0, 0, 1, 1, 32'h1111_1111, 0, "R3");
    step(0, 0, 0, 0, 32'h0, 0, "R10");
    step(1, 0, 1, 0, 32'h7777_7777, 0, "R9");
    step(0, 0, 1, 0, 32'hFFFF_FFFF, 0, "R2");
    step(1, 1, 0, 0, 32'h0, 0, "R9");
    step(0, 0, 1, 1, 32'h0, 0, "R4");
    step(0, 0, 1, 0, 32'h0, 1, "R7");
    step(0, 0, 0, 0, 32'h0, 0, "R10");
    step(0, 0, 1, 0, 32'h0, 0, "R3");
    step(1, 0, 0, 0, 32'h0, 0, "R9");
    step(0, 0, 1, 1, 32'hFFFF_FFFF, 0, "R2");
    step(0, 0, 1, 0, 32'hFFFF_FFFE, 0, "R2");
    step(1, 1, 0, 0, 32'h0, 0, "R9");
    step(0, 0, 1, 0, 32'h0, 0, "R4");
    step(0, 0, 1, 1, 32'h0, 0, "R5");
    step(0, 0, 1, 0, 32'h0, 0, "R6");
    step(0, 0, 0, 0, 32'h0, 0, "R10");
    step(0, 0, 1, 1, 32'h0, 0, "R6");
    step(1, 0, 0, 0, 32'h0, 0, "R9");
    step(0, 0, 1, 0, 32'h0000_0005, 0, "R8");
    step(0, 0, 1, 1, 32'h0000_0007, 0, "R8");
    step(1, 1, 1, 0, 32'h0, 0, "R10");

    for (int i = 0; i < 400; i++) begin
      bit mwe, we, sel, ti;
      logic [HW-1:0] d;
      mwe = ($urandom % 8) == 0;
      we  = ($urandom % 4) != 0;
      sel = $urandom % 2;
      ti  = ($urandom % 6) == 0;
      d   = (($urandom % 5) == 0) ? 32'hFFFF_FFFF : $urandom;
      step(mwe, $urandom % 2, we, sel, d, ti, m_mode ? "R3" : "R2");
    end

    finish_run();
  end
endmodule